// File: doc/BRIEF.md
# Dirty Row Run Coalescer

This block turns a per-row dirty map of a framebuffer into a short list of update rectangles. A scan begins on a start pulse. The block then walks the rows from the top, one row per cycle. It asks an external lookup port whether each row is dirty, and it merges every stretch of consecutive dirty rows into one rectangle that spans the full frame width. A consumer takes the rectangles over a valid/ready handshake. A done pulse marks the end of each scan.

When the caller raises the full-update request with the start pulse (for example after the display geometry changed), the block skips the scan. It issues one rectangle that covers the whole frame. Producing and clearing the dirty bits are left to the surrounding logic.

Top module: `rrc_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `rect_valid_o` and `done_o` are low.
- R2: Rows are read in ascending order, one per cycle, through `lookup_row_o`. When a clean row follows a run of dirty rows, one rectangle is emitted with y equal to the first dirty row of the run and h equal to the clean row index minus that first row.
- R3: A run still open at the last row (index rows-1) is emitted with h equal to the row count minus its first row.
- R4: Every emitted rectangle has x = 0 and w equal to the frame width captured at start.
- R5: With `full_i` high at start, exactly one rectangle (0, 0, width, rows) is emitted, without a row scan. The rectangle is valid in the cycle after start, and `done_o` rises one cycle after it is accepted.
- R6: While `rect_valid_o` is high and `rect_ready_i` is low, the rectangle fields and valid hold steady and the scan does not advance.
- R7: `done_o` is a single-cycle pulse, given once per scan. It comes one cycle after the last rectangle is accepted, or one cycle after the last row is read if nothing is pending. For N clean rows it is high in cycle N+1 after the start cycle.
- R8: A start pulse that arrives while a scan or an emission is in progress has no effect.
- R9: A start with a row count of zero emits no rectangle, and `done_o` is high in the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| full_i | input | 1 | Request one full-frame rectangle instead of a scan |
| rows_i | input | ROW_W | Row count of the frame |
| width_i | input | COL_W | Frame width in pixels |
| lookup_row_o | output | ROW_W | Row whose dirty bit is requested |
| lookup_dirty_i | input | 1 | Dirty bit of `lookup_row_o`, same cycle |
| rect_valid_o | output | 1 | Rectangle on the outputs is valid |
| rect_ready_i | input | 1 | Consumer accepts the rectangle |
| rect_x_o | output | COL_W | Rectangle left edge |
| rect_y_o | output | ROW_W | Rectangle top row |
| rect_w_o | output | COL_W | Rectangle width |
| rect_h_o | output | ROW_W | Rectangle height in rows |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
A run tracker that opens or closes at the wrong row shows up in the very next emitted rectangle, as a shifted y or a wrong h. A lost closing shows up at the final row, as a missing or overlong tail rectangle. A row cursor that skips or stalls wrongly moves the done pulse away from its cycle, which is fixed for an all-clean frame. A handshake fault shows within one cycle of a stall, as changed fields under low ready. A state machine that accepts a second start re-emits rectangles or produces a second done pulse within a few cycles.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2,
    ST_DONE = 2'd3
  } rrc_state_e;
endpackage

// File: rtl/rrc_row_cursor.sv
module rrc_row_cursor #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [ROW_W-1:0] rows_i,
  output logic [ROW_W-1:0] row_o,
  output logic             last_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       row_q <= '0;
    else if (clear_i) row_q <= '0;
    else if (step_i)  row_q <= row_q + 1'b1;
  end

  assign row_o  = row_q;
  assign last_o = (row_q == rows_i - 1'b1);
endmodule

// File: rtl/rrc_run_tracker.sv
module rrc_run_tracker #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] first_o
);
  logic             open_q;
  logic [ROW_W-1:0] first_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      open_q  <= 1'b0;
      first_q <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
    end else if (open_i) begin
      open_q  <= 1'b1;
      first_q <= row_i;
    end
  end

  assign open_o  = open_q;
  assign first_o = first_q;
endmodule

// File: rtl/rrc_rect_reg.sv
module rrc_rect_reg #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] x_i,
  input  logic [ROW_W-1:0] y_i,
  input  logic [COL_W-1:0] w_i,
  input  logic [ROW_W-1:0] h_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             accept_o,
  output logic [COL_W-1:0] x_o,
  output logic [ROW_W-1:0] y_o,
  output logic [COL_W-1:0] w_o,
  output logic [ROW_W-1:0] h_o
);
  logic valid_q;

  assign accept_o = valid_q && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
      w_o     <= '0;
      h_o     <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      x_o     <= x_i;
      y_o     <= y_i;
      w_o     <= w_i;
      h_o     <= h_i;
    end else if (accept_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/rrc_top.sv
module rrc_top #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             full_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] width_i,
  output logic [ROW_W-1:0] lookup_row_o,
  input  logic             lookup_dirty_i,
  output logic             rect_valid_o,
  input  logic             rect_ready_i,
  output logic [COL_W-1:0] rect_x_o,
  output logic [ROW_W-1:0] rect_y_o,
  output logic [COL_W-1:0] rect_w_o,
  output logic [ROW_W-1:0] rect_h_o,
  output logic             done_o
);
  import rrc_pkg::*;

  // Height of a run that starts at first and ends just before past_end.
  function automatic logic [ROW_W-1:0] span_rows(input logic [ROW_W-1:0] first,
                                                 input logic [ROW_W-1:0] past_end);
    return past_end - first;
  endfunction

  rrc_state_e       state_q;
  logic [ROW_W-1:0] rows_q;
  logic [COL_W-1:0] width_q;
  logic             final_q;

  // named internal events
  logic             start_take;
  logic             scanning;
  logic             row_last;
  logic             run_open;
  logic [ROW_W-1:0] run_first;
  logic [ROW_W-1:0] cur_row;
  logic             run_begin;
  logic             run_end_clean;
  logic             run_end_tail;
  logic             emit_ev;
  logic             rect_accept;
  logic             cursor_clear;
  logic             load_rect;
  logic [ROW_W-1:0] load_y;
  logic [ROW_W-1:0] load_h;
  logic [COL_W-1:0] load_w;

  assign start_take    = start_i && (state_q == ST_IDLE);
  assign scanning      = (state_q == ST_SCAN);
  assign run_begin     = scanning && lookup_dirty_i && !run_open;
  assign run_end_clean = scanning && !lookup_dirty_i && run_open;
  assign run_end_tail  = scanning && lookup_dirty_i && row_last;
  assign emit_ev       = run_end_clean || run_end_tail;
  assign cursor_clear  = start_take;

  rrc_row_cursor #(.ROW_W(ROW_W)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cursor_clear),
    .step_i  (scanning),
    .rows_i  (rows_q),
    .row_o   (cur_row),
    .last_o  (row_last)
  );

  rrc_run_tracker #(.ROW_W(ROW_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cursor_clear),
    .open_i  (run_begin),
    .close_i (emit_ev),
    .row_i   (cur_row),
    .open_o  (run_open),
    .first_o (run_first)
  );

  always_comb begin
    load_rect = 1'b0;
    load_y    = '0;
    load_h    = '0;
    load_w    = width_q;
    if (start_take && full_i && (rows_i != '0)) begin
      load_rect = 1'b1;
      load_y    = '0;
      load_h    = rows_i;
      load_w    = width_i;
    end else if (run_end_clean) begin
      load_rect = 1'b1;
      load_y    = run_first;
      load_h    = span_rows(run_first, cur_row);
    end else if (run_end_tail) begin
      load_rect = 1'b1;
      load_y    = run_open ? run_first : cur_row;
      load_h    = span_rows(load_y, rows_q);
    end
  end

  rrc_rect_reg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_rect (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_rect),
    .x_i      ('0),
    .y_i      (load_y),
    .w_i      (load_w),
    .h_i      (load_h),
    .ready_i  (rect_ready_i),
    .valid_o  (rect_valid_o),
    .accept_o (rect_accept),
    .x_o      (rect_x_o),
    .y_o      (rect_y_o),
    .w_o      (rect_w_o),
    .h_o      (rect_h_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      width_q <= '0;
      final_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            rows_q  <= rows_i;
            width_q <= width_i;
            final_q <= 1'b1;
            if (rows_i == '0)  state_q <= ST_DONE;
            else if (full_i)   state_q <= ST_EMIT;
            else               state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (emit_ev) begin
            final_q <= row_last;
            state_q <= ST_EMIT;
          end else if (row_last) begin
            state_q <= ST_DONE;
          end
        end
        ST_EMIT: begin
          if (rect_accept) state_q <= final_q ? ST_DONE : ST_SCAN;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lookup_row_o = cur_row;
  assign done_o       = (state_q == ST_DONE);
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid,
  input logic             ready,
  input logic [COL_W-1:0] x,
  input logic [ROW_W-1:0] y,
  input logic [COL_W-1:0] w,
  input logic [ROW_W-1:0] h,
  input logic             done,
  input logic             scanning,
  input logic [ROW_W-1:0] row
);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(y) && $stable(h) && $stable(w) && $stable(x));
  // R4
  x_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (x == '0));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  h_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (h != '0));
  // R6
  stall_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !scanning |=> $stable(row) || !scanning);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);
endmodule

bind rrc_top rrc_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid    (rect_valid_o),
  .ready    (rect_ready_i),
  .x        (rect_x_o),
  .y        (rect_y_o),
  .w        (rect_w_o),
  .h        (rect_h_o),
  .done     (done_o),
  .scanning (scanning),
  .row      (lookup_row_o)
);

// File: tb/rrc_top_bench.sv
module rrc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12;
  localparam int COL_W = 12;
  localparam int NV = 8;

  // stimulus table: dirty map, row count, full flag, width, stall mode, restart cycle
  localparam logic [31:0] T_BM   [NV] = '{32'h0, 32'hFF, 32'hB6, 32'h1,
                                          32'hAAAA, 32'hF0F0, 32'h8000_0001, 32'hFFFF};
  localparam int          T_ROWS [NV] = '{8, 8, 8, 1, 16, 16, 32, 20};
  localparam bit          T_FULL [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};
  localparam int          T_WID  [NV] = '{640, 800, 320, 64, 1024, 720, 100, 4095};
  localparam int          T_STL  [NV] = '{0, 1, 1, 0, 1, 1, 0, 1};
  localparam int          T_RST  [NV] = '{0, 0, 3, 0, 5, 0, 0, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             start_i = 1'b0;
  logic             full_i = 1'b0;
  logic [ROW_W-1:0] rows_i = '0;
  logic [COL_W-1:0] width_i = '0;
  logic [ROW_W-1:0] lookup_row;
  logic             dirty;
  logic             valid;
  logic             ready = 1'b0;
  logic [COL_W-1:0] rx, rw;
  logic [ROW_W-1:0] ry, rh;
  logic             done;
  logic [31:0]      bm = '0;

  assign dirty = (lookup_row < ROW_W'(32)) ? bm[lookup_row[4:0]] : 1'b0;

  rrc_top #(.ROW_W(ROW_W), .COL_W(COL_W)) u_rrc_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .full_i(full_i),
    .rows_i(rows_i), .width_i(width_i), .lookup_row_o(lookup_row),
    .lookup_dirty_i(dirty), .rect_valid_o(valid), .rect_ready_i(ready),
    .rect_x_o(rx), .rect_y_o(ry), .rect_w_o(rw), .rect_h_o(rh), .done_o(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int ey [32];
  int eh [32];
  int en;
  int last_done_cyc;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build_expected(input logic [31:0] b, input int rows, input bit full);
    bit prev;
    int st;
    en = 0;
    prev = 0;
    st = 0;
    if (rows == 0) return;
    if (full) begin
      ey[0] = 0; eh[0] = rows; en = 1;
      return;
    end
    for (int i = 0; i <= rows; i++) begin
      bit d;
      d = (i < rows) ? b[i] : 1'b0;
      if (d && !prev) st = i;
      if (!d && prev && en < 32) begin
        ey[en] = st; eh[en] = i - st; en++;
      end
      prev = d;
    end
  endtask

  task automatic run_vec(input logic [31:0] b, input int rows, input bit full,
                         input int width, input int stall, input int restart_at,
                         input string req);
    int gy [32];
    int gh [32];
    int got, dones, hold_bad, hy, hh, hw, dcyc;
    bit held;
    got = 0; dones = 0; hold_bad = 0; held = 0; dcyc = 0; hy = 0; hh = 0; hw = 0;
    bm = b; rows_i = ROW_W'(rows); width_i = COL_W'(width); full_i = full;
    build_expected(b, rows, full);
    @(negedge clk);
    start_i = 1'b1;
    for (int cyc = 1; cyc <= 400; cyc++) begin
      @(negedge clk);
      start_i = (cyc == restart_at);
      if (held && (!valid || int'(ry) != hy || int'(rh) != hh || int'(rw) != hw))
        hold_bad++;
      ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (valid) begin
        // R4: every rectangle starts at x = 0 and spans the frame width
        check(rx == '0 && int'(rw) == width, "R4", "x/w", int'(rx) + int'(rw), width);
      end
      if (valid && ready) begin
        if (got < 32) begin gy[got] = int'(ry); gh[got] = int'(rh); end
        got++;
      end
      held = valid && !ready;
      hy = int'(ry); hh = int'(rh); hw = int'(rw);
      if (done) begin
        dones++;
        if (dcyc == 0) dcyc = cyc;
      end
      if (dcyc != 0 && cyc >= dcyc + 8) break;
    end
    start_i = 1'b0;
    ready = 1'b0;
    last_done_cyc = dcyc;
    check(got == en, req, "rect count", got, en);
    for (int i = 0; i < en && i < got && i < 32; i++) begin
      check(gy[i] == ey[i], req, "rect y", gy[i], ey[i]);
      check(gh[i] == eh[i], req, "rect h", gh[i], eh[i]);
    end
    // R7 and R8: exactly one done pulse per accepted start
    check(dones == 1, "R7/R8", "done pulses", dones, 1);
    if (stall != 0) check(hold_bad == 0, "R6", "hold violations", hold_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!valid && !done, "R1", "valid|done in reset", int'(valid | done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !done, "R1", "valid|done after reset", int'(valid | done), 0);

    for (int v = 0; v < NV; v++) begin
      run_vec(T_BM[v], T_ROWS[v], T_FULL[v], T_WID[v], T_STL[v], T_RST[v],
              T_FULL[v] ? "R5" : "R2/R3");
    end

    // R7: five clean rows, done in cycle N+1 after start
    run_vec(32'h0, 5, 1'b0, 200, 0, 0, "R7");
    check(last_done_cyc == 6, "R7", "done cycle clean", last_done_cyc, 6);

    // R5: full request, done one cycle after the single accept
    run_vec(32'h5, 10, 1'b1, 300, 0, 0, "R5");
    check(last_done_cyc == 2, "R5", "done cycle full", last_done_cyc, 2);

    // R9: zero rows, no rectangle, done at once
    run_vec(32'hFFFF_FFFF, 0, 1'b0, 300, 0, 0, "R9");
    check(last_done_cyc == 1, "R9", "done cycle empty", last_done_cyc, 1);

    // R3: last row alone dirty, tail of height one
    run_vec(32'h80, 8, 1'b0, 64, 1, 4, "R3");
    check(last_done_cyc >= 9, "R3", "tail done cycle", last_done_cyc, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule